// File: doc/BRIEF.md
# Sequential Booth Multiplier

This block forms the full double-width product of two WIDTH-bit operands over WIDTH clock cycles. It uses one adder/subtractor of WIDTH+1 bits and one double-width shift register. The upper half of that register collects the running partial product. The lower half starts out holding the multiplier and is consumed one bit per step as the register shifts right. When the run ends, the upper half is the high word of the product and the lower half is the low word.

A select input picks the operand encoding when an operation is accepted. For two's-complement operands, each step recodes the pair made of the current low bit and the bit shifted out before it, using the radix-2 Booth scheme, and the register shifts arithmetically. For unsigned operands, the multiplicand is added whenever the low bit is one, and the carry out of the adder enters at the top during the shift.

A caller pulses `start` with the operands while the block is idle. It then waits for the one-cycle `done` pulse and reads `hi` and `lo`. Both words hold their value until the next operation is accepted.

Top module: `booth_seq_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `hi` and `lo` are all zeros.
- R2: If `start` is 1 while `busy` is 0 at a rising edge, the operation is accepted and `busy` reads 1 in the following cycle.
- R3: An accepted operation performs exactly WIDTH steps. `busy` stays 1 for WIDTH cycles and falls at the same edge where `done` rises.
- R4: `done` is 1 for exactly one cycle per operation and is never 1 together with `busy`.
- R5: With `is_signed` = 1, {`hi`,`lo`} equals the two's-complement product of `op_a` and `op_b`. Pair (low bit, previous bit) = 10 subtracts the multiplicand, 01 adds it, and 00 or 11 leaves the partial product unchanged.
- R6: With `is_signed` = 0, {`hi`,`lo`} equals the unsigned product of `op_a` and `op_b`.
- R7: `start` is ignored while `busy` is 1. The running result and its timing come only from the accepted operands.
- R8: `hi` and `lo` keep the final product unchanged while idle and until the next operation is accepted.
- R9: Extreme operands give exact products: the most negative value times itself or times one in signed mode, and all-ones times all-ones in unsigned mode.
- R10: A WIDTH = 4 instance gives 2 × 7 = 14 (8'h0E) and 2 × −3 = −6 (8'hFA) in signed mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new multiplication while idle |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| op_a | input | WIDTH | Multiplicand |
| op_b | input | WIDTH | Multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| hi | output | WIDTH | Upper word of the product |
| lo | output | WIDTH | Lower word of the product |

## Verification
Suppose a start is accepted at edge k. `busy` is first observed high in the cycle after edge k. `done`, the falling `busy` and the final `hi`/`lo` all appear in the cycle after edge k+WIDTH, and `done` is low again after edge k+WIDTH+1. The bench drives inputs and samples outputs on falling edges and counts falling edges from the accepting edge. It checks `busy` in every running cycle, checks that `done` is still low one cycle before it is due, and reads the product only in the `done` cycle. It samples again a few idle cycles later to confirm the product is held.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_ADD  = 2'd1,
        ACT_SUB  = 2'd2
    } act_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } st_e;

    // Step action: Booth pair in signed mode, plain bit test otherwise.
    function automatic act_e pick_act(input logic sgn, input logic cur, input logic prev);
        act_e a;
        if (sgn) begin
            case ({cur, prev})
                2'b10:   a = ACT_SUB;
                2'b01:   a = ACT_ADD;
                default: a = ACT_NONE;
            endcase
        end else begin
            a = cur ? ACT_ADD : ACT_NONE;
        end
        return a;
    endfunction

endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl #(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    import mulseq_pkg::*;

    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    st_e           state;
    logic [CW-1:0] cnt;
    logic          done_q;

    assign load = start && (state == ST_IDLE);
    assign step = (state == ST_RUN);
    assign busy = (state == ST_RUN);
    assign done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_RUN;
                        cnt   <= '0;
                    end
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mul_step.sv
module mul_step #(
    parameter int WIDTH = 32
) (
    input  logic             sgn,
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] mq,
    input  logic             prev,
    input  logic [WIDTH-1:0] mcand,
    output logic [WIDTH-1:0] acc_n,
    output logic [WIDTH-1:0] mq_n,
    output logic             prev_n
);
    import mulseq_pkg::*;

    localparam int EW = WIDTH + 1;

    act_e          act;
    logic [EW-1:0] ext_acc;
    logic [EW-1:0] ext_m;
    logic [EW-1:0] operand;
    logic [EW-1:0] sum;

    always_comb begin
        act     = pick_act(sgn, mq[0], prev);
        ext_acc = {sgn & acc[WIDTH-1], acc};
        ext_m   = {sgn & mcand[WIDTH-1], mcand};
        case (act)
            ACT_ADD: operand = ext_m;
            ACT_SUB: operand = ~ext_m;
            default: operand = '0;
        endcase
        sum    = ext_acc + operand + EW'(act == ACT_SUB);
        acc_n  = sum[EW-1:1];
        mq_n   = {sum[0], mq[WIDTH-1:1]};
        prev_n = mq[0];
    end
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             is_signed,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] hi,
    output logic [WIDTH-1:0] lo
);
    logic             load, step;
    logic [WIDTH-1:0] acc_q, mq_q, mcand_q;
    logic             prev_q, sgn_q;
    logic [WIDTH-1:0] acc_n, mq_n;
    logic             prev_n;

    mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .load(load), .step(step), .busy(busy), .done(done)
    );

    mul_step #(.WIDTH(WIDTH)) u_step (
        .sgn(sgn_q), .acc(acc_q), .mq(mq_q), .prev(prev_q), .mcand(mcand_q),
        .acc_n(acc_n), .mq_n(mq_n), .prev_n(prev_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            mq_q    <= '0;
            mcand_q <= '0;
            prev_q  <= 1'b0;
            sgn_q   <= 1'b0;
        end else if (load) begin
            acc_q   <= '0;
            mq_q    <= op_b;
            mcand_q <= op_a;
            prev_q  <= 1'b0;
            sgn_q   <= is_signed;
        end else if (step) begin
            acc_q  <= acc_n;
            mq_q   <= mq_n;
            prev_q <= prev_n;
        end
    end

    assign hi = acc_q;
    assign lo = mq_q;
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] hi,
    input logic [WIDTH-1:0] lo
);
    localparam int LW = $clog2(WIDTH + 2) + 1;
    logic [LW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)                run_len <= '0;
        else if (start && !busy) run_len <= '0;
        else if (busy)          run_len <= run_len + 1'b1;
    end

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> (!busy && !done && hi == '0 && lo == '0));
    p_accept_r2:     assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);
    p_len_r3:        assert property (@(posedge clk) disable iff (rst) done |-> (run_len == LW'(WIDTH)));
    p_end_r3:        assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
    p_pulse_r4:      assert property (@(posedge clk) disable iff (rst) done |=> !done);
    p_excl_r4:       assert property (@(posedge clk) disable iff (rst) !(done && busy));
    p_keep_run_r7:   assert property (@(posedge clk) disable iff (rst) busy |=> (busy || done));
    p_hold_r8:       assert property (@(posedge clk) disable iff (rst) (!busy && !start) |=> ($stable(hi) && $stable(lo)));
endmodule

bind booth_seq_mul booth_mul_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .hi(hi), .lo(lo)
);

// File: tb/sim_booth_seq_mul.sv
module sim_booth_seq_mul;
    localparam int W  = 32;
    localparam int WS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          start = 1'b0, is_signed = 1'b0;
    logic [W-1:0]  op_a = '0, op_b = '0;
    logic          busy, done;
    logic [W-1:0]  hi, lo;

    logic          s_start = 1'b0;
    logic [WS-1:0] s_a = '0, s_b = '0;
    logic          s_busy, s_done;
    logic [WS-1:0] s_hi, s_lo;

    int total = 0;
    int bad   = 0;

    booth_seq_mul #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .start(start), .is_signed(is_signed),
        .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .hi(hi), .lo(lo)
    );

    booth_seq_mul #(.WIDTH(WS)) u1 (
        .clk(clk), .rst(rst), .start(s_start), .is_signed(1'b1),
        .op_a(s_a), .op_b(s_b), .busy(s_busy), .done(s_done), .hi(s_hi), .lo(s_lo)
    );

    function automatic logic [63:0] ref_prod(input logic [W-1:0] a, input logic [W-1:0] b, input logic sgn);
        logic [63:0] ea, eb;
        ea = sgn ? {{32{a[W-1]}}, a} : {32'b0, a};
        eb = sgn ? {{32{b[W-1]}}, b} : {32'b0, b};
        return ea * eb;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one operation; optionally pulse start again mid-run (R7).
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic sgn,
                          input string req, input bit disturb);
        logic [63:0] exp;
        exp = ref_prod(a, b, sgn);
        @(negedge clk);
        op_a = a; op_b = b; is_signed = sgn; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", {63'b0, busy}, 64'd1);
        for (int i = 1; i < W; i++) begin
            if (disturb && i == 5) begin
                op_a = ~a; op_b = b ^ 32'h5A5A_1234; is_signed = ~sgn; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            if (busy !== 1'b1 || done !== 1'b0) check("R3 running", {62'b0, busy, done}, 64'd2);
        end
        check("R3 done not early", {63'b0, done}, 64'd0);
        @(negedge clk);
        check("R3 done due", {62'b0, done, busy}, 64'd2);
        check(req, {hi, lo}, exp);
        @(negedge clk);
        check("R4 done single", {63'b0, done}, 64'd0);
        repeat (3) @(negedge clk);
        check("R8 held", {hi, lo}, exp);
    endtask

    task automatic run_small(input logic [WS-1:0] a, input logic [WS-1:0] b, input logic [7:0] exp);
        @(negedge clk);
        s_a = a; s_b = b; s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        repeat (WS - 1) @(negedge clk);
        check("R10 not early", {63'b0, s_done}, 64'd0);
        @(negedge clk);
        check("R10 done", {63'b0, s_done}, 64'd1);
        check("R10 product", {56'b0, s_hi, s_lo}, {56'b0, exp});
    endtask

    initial begin
        #(20 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] ra, rb;
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset", {busy, done, hi, lo}, 64'd0);
        check("R1 reset hi", {32'b0, hi}, 64'd0);

        run_small(4'd2, 4'd7, 8'h0E);
        run_small(4'd2, 4'hD, 8'hFA);

        run_op(32'd6, 32'd7, 1'b1, "R5 small signed", 1'b0);
        run_op(32'hFFFF_FFFD, 32'd2, 1'b1, "R5 neg x pos", 1'b0);
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R9 unsigned max", 1'b0);
        run_op(32'h8000_0000, 32'h8000_0000, 1'b1, "R9 minneg squared", 1'b0);
        run_op(32'h8000_0000, 32'd1, 1'b1, "R9 minneg x one", 1'b0);
        run_op(32'hFFFF_FFFD, 32'd2, 1'b0, "R6 unsigned pattern", 1'b0);
        run_op(32'h1234_5678, 32'h8765_4321, 1'b1, "R7 start ignored", 1'b1);

        for (int k = 0; k < 40; k++) begin
            ra = $urandom; rb = $urandom;
            run_op(ra, rb, 1'b1, "R5 random signed", 1'b0);
            ra = $urandom; rb = $urandom;
            run_op(ra, rb, 1'b0, "R6 random unsigned", 1'b0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule